// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a register-based model of a pipelined synchronous static RAM in which a read may follow a write, or a write a read, on the very next clock with no idle slot on the data bus. Every command is captured on a rising edge. The result of that command resolves two enabled edges later: read data is driven out, or write data is taken in. Because both directions use the same pipeline depth, a change of direction never needs a gap.

A command is started with the load strobe low while all three chip selects are active. With the load strobe high, the block continues the current burst instead. The next address is produced by a 2-bit counter that steps the two low address bits and wraps inside an aligned group of four. The direction stays the same as the burst's first beat. Writes are masked per byte.

The data output is a stream with a valid flag (`dout_en`), which stands in for the output enable of a shared bus. There is no ready input. The only back-pressure is the active-low clock enable, which freezes the whole pipeline, the output register included, for as long as it is high.

Top module: `zbt_sram`

## Requirements
- R1: After reset, `dout_en` is 0 and `dout` is 0.
- R2: A read command captured at enabled edge E puts the stored word on `dout`, with `dout_en` = 1, right after the second enabled edge that follows E.
- R3: For a write command captured at enabled edge E, `din` is sampled at the second enabled edge that follows E.
- R4: Reads and writes may be issued on consecutive cycles in any mix. A read issued after a write to the same address returns the new data.
- R5: `byte_wr_n[i]` low enables byte i (`din[8i+7:8i]`) on a write. Bytes whose select is high keep their old value.
- R6: While `cke_n` is high, all inputs are ignored and every pipeline register, `dout` and `dout_en` hold their values.
- R7: The block is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. With `load_n` low and the block not selected, no command starts and any burst ends.
- R8: Reads and writes already in the pipeline complete after a deselect.
- R9: After the second enabled edge following a write, a deselect or an idle slot, `dout_en` is 0.
- R10: With `load_n` high during a burst, the next beat uses the same direction. Its address has the same upper bits and the low two bits plus one, modulo 4. The beat uses its own `byte_wr_n` and ignores `wr_n`, `addr` and the chip selects.
- R11: With `load_n` high and no burst active, no command starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable (stall when high) |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low: load new command; high: advance burst |
| wr_n | input | 1 | Low: write, high: read (at load) |
| byte_wr_n | input | BYTES | Active-low per-byte write selects |
| addr | input | ADDR_W | Word address |
| din | input | BYTES*BYTE_W | Write data |
| dout | output | BYTES*BYTE_W | Read data |
| dout_en | output | 1 | Read data valid / output enable |

## Verification
Every result is due exactly two enabled edges after its command edge. A write's data is also consumed at that second edge. The bench queues one expected item for each enabled command edge and compares the oldest item once three are queued, which is the edge at which that item resolves. Stalled edges add nothing to the queue. On those edges the bench instead checks that `dout` and `dout_en` did not change. The bench applies write data to its reference array at the same edge where it checks reads, so read-after-write ordering follows from that timing alone.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/zbt_cmd.sv
`timescale 1ns/1ps
// Command capture and burst address generation (pipeline stage 1).
module zbt_cmd
  import zbt_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BYTES   = 4,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              load_n,
  input  logic              wr_n,
  input  logic [BYTES-1:0]  byte_wr_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [BYTES-1:0]  s1_be
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic              sel;
  op_e               nxt_op;
  logic [ADDR_W-1:0] nxt_addr;
  logic [BYTES-1:0]  nxt_be;

  always_comb begin
    sel      = !sel_a_n && sel_b && !sel_c_n;
    nxt_op   = OP_NONE;
    nxt_addr = s1_addr;
    nxt_be   = '0;
    if (!load_n) begin
      if (sel) begin
        nxt_op   = wr_n ? OP_RD : OP_WR;
        nxt_addr = addr;
      end
    end else if (s1_op != OP_NONE) begin
      nxt_op   = s1_op;
      nxt_addr = {s1_addr[ADDR_W-1:BURST_W],
                  s1_addr[BURST_W-1:0] + BURST_W'(1)};
    end
    if (nxt_op == OP_WR) nxt_be = ~byte_wr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_NONE;
      s1_addr <= '0;
      s1_be   <= '0;
    end else if (en) begin
      s1_op   <= nxt_op;
      s1_addr <= nxt_addr;
      s1_be   <= nxt_be;
    end
  end

  // R7: a load slot without full select yields no command
  p_deselect_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load_n && !(!sel_a_n && sel_b && !sel_c_n)) |=> (s1_op == OP_NONE));

  // R10: advancing keeps direction and the upper address bits
  p_burst_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load_n && s1_op != OP_NONE) |=>
      (s1_op == $past(s1_op) &&
       s1_addr[ADDR_W-1:BURST_W] == $past(s1_addr[ADDR_W-1:BURST_W])));

  // R11: advancing with no burst active starts nothing
  p_idle_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load_n && s1_op == OP_NONE) |=> (s1_op == OP_NONE));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = addr[ADDR_W-1:BURST_W];
endmodule

// File: rtl/zbt_stage.sv
`timescale 1ns/1ps
// Second pipeline register; keeps read and write resolution aligned.
module zbt_stage
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  op_e               s1_op,
  input  logic [ADDR_W-1:0] s1_addr,
  input  logic [BYTES-1:0]  s1_be,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [BYTES-1:0]  s2_be
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_op   <= OP_NONE;
      s2_addr <= '0;
      s2_be   <= '0;
    end else if (en) begin
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  // R6: a stalled edge leaves the stage untouched
  p_stage_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(s2_op) && $stable(s2_addr) && $stable(s2_be)));
endmodule

// File: rtl/zbt_mem.sv
`timescale 1ns/1ps
// Storage array: write commit and read output at the same pipeline slot.
module zbt_mem
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  op_e                     s2_op,
  input  logic [ADDR_W-1:0]       s2_addr,
  input  logic [BYTES-1:0]        s2_be,
  input  logic [BYTES*BYTE_W-1:0] din,
  output logic [BYTES*BYTE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DATA_W = BYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (en && s2_op == OP_WR && s2_be[b])
        mem[s2_addr][b*BYTE_W +: BYTE_W] <= din[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else if (en) begin
      dout_en <= (s2_op == OP_RD);
      if (s2_op == OP_RD) dout <= mem[s2_addr];
    end
  end

  // R2: a read reaching this slot drives valid data next
  p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s2_op == OP_RD) |=> dout_en);

  // R9: writes, deselects and idle slots release the bus
  p_bus_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s2_op != OP_RD) |=> !dout_en);

  // R6: output register frozen while stalled
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(dout) && $stable(dout_en)));
endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    load_n,
  input  logic                    wr_n,
  input  logic [BYTES-1:0]        byte_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] din,
  output logic [BYTES*BYTE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int BURST_W = 2;

  logic              en;
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [BYTES-1:0]  s1_be, s2_be;

  assign en = !cke_n;

  zbt_cmd #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BURST_W(BURST_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .en(en),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .load_n(load_n), .wr_n(wr_n), .byte_wr_n(byte_wr_n), .addr(addr),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be)
  );

  zbt_stage #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_stage (
    .clk(clk), .rst_n(rst_n), .en(en),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_be(s2_be)
  );

  zbt_mem #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .en(en),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_be(s2_be),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  // R8: a command two slots deep resolves even if the bus is deselected now
  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s2_op == OP_RD && !load_n && sel_b == 1'b0) |=> dout_en);
endmodule

// File: tb/zbt_sram_tb_top.sv
`timescale 1ns/1ps
module zbt_sram_tb_top;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cke_n = 1'b0, sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic          load_n = 1'b0, wr_n = 1'b1;
  logic [NB-1:0] byte_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  zbt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .load_n(load_n), .wr_n(wr_n), .byte_wr_n(byte_wr_n), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  // op codes used by the model: 0 none, 1 read, 2 write
  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] a;
    logic [NB-1:0] be;
    logic [7:0]    tag;
  } item_t;

  item_t         exp_q[$];
  logic [DW-1:0] model [1<<AW];
  logic [1:0]    b_op = 2'd0;
  logic [AW-1:0] b_addr = '0;
  logic [DW-1:0] prev_dout = '0;
  logic          prev_en = 1'b0;

  task automatic check(input bit ok, input int tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Driver: one clock slot; pushes the expected item for enabled slots
  task automatic slot(input logic ld_n, input logic sa_n, input logic sb,
                      input logic sc_n, input logic w_n, input logic [NB-1:0] bwn,
                      input logic [AW-1:0] a, input logic ckn, input int tag);
    item_t it;
    @(negedge clk);
    load_n = ld_n; sel_a_n = sa_n; sel_b = sb; sel_c_n = sc_n;
    wr_n = w_n; byte_wr_n = bwn; addr = a; cke_n = ckn;
    seed = seed * 32'd1103515245 + 32'd12345;
    din = seed;
    if (!ckn) begin
      it.op = 2'd0; it.a = b_addr; it.be = '0; it.tag = 8'(tag);
      if (!ld_n) begin
        if (!sa_n && sb && !sc_n) begin it.op = w_n ? 2'd1 : 2'd2; it.a = a; end
      end else if (b_op != 2'd0) begin
        it.op = b_op; it.a = {b_addr[AW-1:2], b_addr[1:0] + 2'd1};
      end
      if (it.op == 2'd2) it.be = ~bwn;
      b_op = it.op; b_addr = it.a;
      exp_q.push_back(it);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input int tag);
    slot(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, '1, a, 1'b0, tag);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] bwn, input int tag);
    slot(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, bwn, a, 1'b0, tag);
  endtask
  // advance with chip selects off and wr_n toggled: both must be ignored (R10)
  task automatic adv(input logic w_n, input logic [NB-1:0] bwn, input int tag);
    slot(1'b1, 1'b1, 1'b0, 1'b1, w_n, bwn, 6'h3F, 1'b0, tag);
  endtask
  task automatic desel(input int tag);
    slot(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 6'h05, 1'b0, tag);
  endtask
  task automatic stall(input int tag);
    slot(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 6'h07, 1'b1, tag);
  endtask

  // Monitor: pops an item when it reaches the output slot
  always @(posedge clk) begin
    item_t it;
    #1;
    if (rst_n && !done) begin
      if (cke_n) begin
        check(dout == prev_dout && dout_en == prev_en, 6, dout, prev_dout); // R6
      end else if (exp_q.size() == 3) begin
        it = exp_q.pop_front();
        if (it.op == 2'd1) begin
          check(dout_en == 1'b1 && dout == model[it.a], int'(it.tag), dout, model[it.a]);
        end else begin
          // R9: bus released for write/idle slots
          check(dout_en == 1'b0, int'(it.tag), {31'd0, dout_en}, '0);
          if (it.op == 2'd2)
            for (int b = 0; b < NB; b++)
              if (it.be[b]) model[it.a][b*8 +: 8] = din[b*8 +: 8];
        end
      end
      prev_dout = dout; prev_en = dout_en;
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dout_en == 1'b0 && dout == '0, 1, dout, '0);
    rst_n = 1'b1;
    repeat (2) desel(9);

    // R10 / R3: four-beat write burst from 8, beats ignore wr_n
    wr(6'd8, 4'b0000, 3);
    adv(1'b1, 4'b0000, 10); adv(1'b1, 4'b0000, 10); adv(1'b0, 4'b0000, 10);
    // R4 / R10: read burst starting at 10 wraps to 8,9, right after the writes
    rd(6'd10, 4);
    adv(1'b0, 4'b0000, 10); adv(1'b0, 4'b0000, 10); adv(1'b1, 4'b0000, 10);

    // R4: alternating directions, read-after-write on one address
    wr(6'd20, 4'b0000, 4); rd(6'd20, 4); wr(6'd21, 4'b0000, 4);
    rd(6'd20, 4); rd(6'd21, 4); wr(6'd20, 4'b0000, 4); rd(6'd20, 4);

    // R5: only bytes 0 and 2 written
    wr(6'd20, 4'b1010, 5); rd(6'd20, 5); wr(6'd21, 4'b0111, 5); rd(6'd21, 5);

    // R6: stall between write command and its data slot
    wr(6'd30, 4'b0000, 6); stall(6); stall(6); desel(6); rd(6'd30, 6);
    rd(6'd8, 6); stall(6); stall(6); stall(6); desel(6); desel(6);

    // R8: commands in flight finish after deselect; R9: bus released after
    rd(6'd9, 8); wr(6'd12, 4'b0000, 8); desel(8); desel(9); desel(9); rd(6'd12, 8);

    // R11: advancing with nothing active stays idle
    desel(11); adv(1'b1, 4'b0000, 11); adv(1'b0, 4'b0000, 11); desel(11);

    // R7: deselect ends a burst; a later advance starts nothing
    rd(6'd8, 7); adv(1'b1, 4'b0000, 7); desel(7); adv(1'b1, 4'b0000, 7); adv(1'b1, 4'b0000, 7);

    // R10: long write burst wraps 40..43,40,41 with per-beat selects
    wr(6'd40, 4'b0000, 10); adv(1'b1, 4'b0000, 10); adv(1'b1, 4'b0000, 10);
    adv(1'b1, 4'b0000, 10); adv(1'b1, 4'b1100, 10); adv(1'b1, 4'b0011, 10);
    rd(6'd40, 10); adv(1'b0, 4'b0000, 10); adv(1'b0, 4'b0000, 10); adv(1'b0, 4'b0000, 10);

    // R2: isolated read with idle slots around it
    desel(2); rd(6'd11, 2); desel(2); desel(2); desel(2);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    report();
    $finish;
  end
endmodule